// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block supervises software through an absolute deadline held against a free-running 64-bit system count that the chip supplies. Software arms it by setting the enable bit and then keeps it alive by refreshing. A refresh sets the deadline to the current count plus a programmed 32-bit interval. If the count reaches the deadline first, the block raises a warning line meant for an interrupt and moves the deadline one more interval ahead. If that second deadline also passes without a refresh, the block asserts a reset request.

Two register ports are provided. The refresh port is a bare write strobe with an address: a write to offset 0x000 refreshes the timer and the data carries no meaning. The control port reads and writes the settings. A write to the settings register always refreshes. A write to the interval register refreshes only while the timer is armed. The reset-request status is sticky through the warm reset it causes, so software can tell after reboot why the chip restarted. Only a separate power-on reset clears it.

Top module: `twostage_wdog`

## Requirements
- R1: After power-on reset (`por`), both stage outputs are 0. The settings, interval and both deadline words read 0.
- R2: A control-port write to the settings register (0x000) loads enable from data bit 0 and always counts as a refresh. A refresh sets the deadline to count plus interval and clears the warning stage.
- R3: A refresh-port write to offset 0x000 is a refresh whatever its data. A refresh-port write to any other offset has no effect.
- R4: A write to the interval register (0x008) stores the value. While enabled, the write also refreshes, and the deadline becomes count plus the new interval. While disabled, the deadline is left unchanged.
- R5: When enabled, with the warning stage clear and count >= deadline, the next edge sets `stage1_irq` and reloads the deadline to count plus interval.
- R6: When enabled, with the warning stage set and count >= deadline, the next edge sets `stage2_rst`. Once set, it stays set until `por`.
- R7: While disabled, no expiry occurs, however far the count has passed the deadline.
- R8: Writes to the deadline words (low at 0x010, high at 0x014) replace that half and leave both stage bits unchanged.
- R9: The stage bits cannot be written. A settings write with bits 1 and 2 set neither sets nor clears them, apart from the warning clear that the refresh itself performs.
- R10: A warm reset (`rst`) clears enable, the warning stage, the interval and the deadline, and keeps `stage2_rst` and its status bit.
- R11: Control-port reads return their data one cycle after the address. The settings register reads as bit 0 enable, bit 1 warning stage, bit 2 reset stage. Offsets 0xFCC and 0xFD0 return the parameters `IFACE_ID` and `PART_ID`. Unmapped offsets read 0.
- R12: A refresh in the same cycle as an expiry wins: neither stage bit is set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_count | input | 64 | Free-running system count |
| rf_wr | input | 1 | Refresh-port write strobe |
| rf_addr | input | 12 | Refresh-port byte offset |
| cf_wr | input | 1 | Control-port write strobe |
| cf_addr | input | 12 | Control-port byte offset, used for both reads and writes |
| cf_wdata | input | 32 | Control-port write data |
| cf_rdata | output | 32 | Control-port read data, registered |
| stage1_irq | output | 1 | Warning stage, registered |
| stage2_rst | output | 1 | Reset-request stage, registered and sticky |

## Verification
The assertions assume that `sys_count` does not wrap, so count plus interval never overflows. They also assume that at most one control-port write arrives per cycle. The reload check further relies on the interval being stable in any cycle where the warning stage rises, which holds because an interval write while armed is a refresh and so suppresses expiry. The bench drives `sys_count` as a held value that it steps forward between checks, never backwards and far below the wrap point. This lets it place the count exactly one below and exactly on each deadline.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [11:0] OFS_SETTINGS = 12'h000;
  localparam logic [11:0] OFS_INTERVAL = 12'h008;
  localparam logic [11:0] OFS_DL_LO    = 12'h010;
  localparam logic [11:0] OFS_DL_HI    = 12'h014;
  localparam logic [11:0] OFS_IFACE    = 12'hFCC;
  localparam logic [11:0] OFS_PART     = 12'hFD0;
  localparam logic [11:0] OFS_KICK     = 12'h000;

  localparam int BIT_EN = 0;
  localparam int BIT_S1 = 1;
  localparam int BIT_S2 = 2;

  typedef struct packed {
    logic settings;
    logic interval;
    logic dl_lo;
    logic dl_hi;
    logic kick;
  } wdog_wr_t;

endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              cf_wr,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic              rf_wr,
  input  logic [ADDR_W-1:0] rf_addr,
  output wdog_wr_t          wr
);
  always_comb begin
    wr          = '0;
    wr.settings = cf_wr && (cf_addr == ADDR_W'(OFS_SETTINGS));
    wr.interval = cf_wr && (cf_addr == ADDR_W'(OFS_INTERVAL));
    wr.dl_lo    = cf_wr && (cf_addr == ADDR_W'(OFS_DL_LO));
    wr.dl_hi    = cf_wr && (cf_addr == ADDR_W'(OFS_DL_HI));
    wr.kick     = rf_wr && (rf_addr == ADDR_W'(OFS_KICK));
  end
endmodule

// File: rtl/wdog_deadline.sv
module wdog_deadline
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [CNT_W-1:0]  sys_count,
  input  wdog_wr_t          wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en_q,
  input  logic              stage1_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [DATA_W-1:0] offset_q,
  output logic              refresh,
  output logic              expire
);
  logic [DATA_W-1:0] next_ofs;
  logic [CNT_W-1:0]  reload;
  logic              hold;

  always_comb begin
    refresh  = wr.settings | wr.kick | (wr.interval & en_q);
    hold     = refresh | wr.dl_lo | wr.dl_hi;
    expire   = en_q && !hold && (sys_count >= cmp_q);
    next_ofs = wr.interval ? wdata : offset_q;
    reload   = sys_count + CNT_W'(next_ofs);
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      cmp_q    <= '0;
      offset_q <= '0;
    end else begin
      if (wr.interval) offset_q <= wdata;
      if (refresh)
        cmp_q <= reload;
      else if (wr.dl_lo)
        cmp_q[DATA_W-1:0] <= wdata;
      else if (wr.dl_hi)
        cmp_q[CNT_W-1:DATA_W] <= wdata;
      else if (expire && !stage1_q)
        cmp_q <= reload;
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic settings_wr,
  input  logic en_bit,
  input  logic refresh,
  input  logic expire,
  output logic en_q,
  output logic stage1_q,
  output logic stage2_q
);
  always_ff @(posedge clk) begin
    if (rst || por) begin
      en_q     <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      if (settings_wr) en_q <= en_bit;
      if (refresh)
        stage1_q <= 1'b0;
      else if (expire)
        stage1_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por)
      stage2_q <= 1'b0;
    else if (!rst && expire && stage1_q)
      stage2_q <= 1'b1;
  end
endmodule

// File: rtl/wdog_readback.sv
module wdog_readback
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IFACE_ID = '0,
  parameter logic [DATA_W-1:0] PART_ID  = '0,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              en_q,
  input  logic              stage1_q,
  input  logic              stage2_q,
  input  logic [DATA_W-1:0] offset_q,
  input  logic [CNT_W-1:0]  cmp_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] sel;

  always_comb begin
    status         = '0;
    status[BIT_EN] = en_q;
    status[BIT_S1] = stage1_q;
    status[BIT_S2] = stage2_q;
    case (rd_addr)
      ADDR_W'(OFS_SETTINGS): sel = status;
      ADDR_W'(OFS_INTERVAL): sel = offset_q;
      ADDR_W'(OFS_DL_LO):    sel = cmp_q[DATA_W-1:0];
      ADDR_W'(OFS_DL_HI):    sel = cmp_q[CNT_W-1:DATA_W];
      ADDR_W'(OFS_IFACE):    sel = IFACE_ID;
      ADDR_W'(OFS_PART):     sel = PART_ID;
      default:               sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || por) rdata <= '0;
    else            rdata <= sel;
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IFACE_ID = 32'h0001_043B,
  parameter logic [DATA_W-1:0] PART_ID  = 32'h0000_0A55,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              rf_wr,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic              cf_wr,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic [DATA_W-1:0] cf_wdata,
  output logic [DATA_W-1:0] cf_rdata,
  output logic              stage1_irq,
  output logic              stage2_rst
);
  wdog_wr_t          wr;
  logic              en_q;
  logic              stage1_q;
  logic              stage2_q;
  logic              refresh;
  logic              expire;
  logic [CNT_W-1:0]  cmp_q;
  logic [DATA_W-1:0] offset_q;

  wdog_decode #(.ADDR_W(ADDR_W)) u_decode (
    .cf_wr(cf_wr), .cf_addr(cf_addr), .rf_wr(rf_wr), .rf_addr(rf_addr), .wr(wr)
  );

  wdog_deadline #(.DATA_W(DATA_W)) u_deadline (
    .clk(clk), .rst(rst), .por(por), .sys_count(sys_count), .wr(wr),
    .wdata(cf_wdata), .en_q(en_q), .stage1_q(stage1_q), .cmp_q(cmp_q),
    .offset_q(offset_q), .refresh(refresh), .expire(expire)
  );

  wdog_stage u_stage (
    .clk(clk), .rst(rst), .por(por), .settings_wr(wr.settings),
    .en_bit(cf_wdata[BIT_EN]), .refresh(refresh), .expire(expire),
    .en_q(en_q), .stage1_q(stage1_q), .stage2_q(stage2_q)
  );

  wdog_readback #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IFACE_ID(IFACE_ID), .PART_ID(PART_ID)
  ) u_readback (
    .clk(clk), .rst(rst), .por(por), .rd_addr(cf_addr), .en_q(en_q),
    .stage1_q(stage1_q), .stage2_q(stage2_q), .offset_q(offset_q),
    .cmp_q(cmp_q), .rdata(cf_rdata)
  );

  assign stage1_irq = stage1_q;
  assign stage2_rst = stage2_q;
endmodule

// File: rtl/twostage_wdog_chk.sv
module twostage_wdog_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              en_q,
  input logic              stage1_irq,
  input logic              stage2_rst,
  input logic              rf_wr,
  input logic [ADDR_W-1:0] rf_addr,
  input logic [CNT_W-1:0]  sys_count,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [DATA_W-1:0] offset_q
);
  // R6: reset request is sticky until power-on reset
  assert_stage2_sticky_R6: assert property (@(posedge clk) disable iff (por)
    stage2_rst |=> stage2_rst);

  // R6: reset request only follows a warning
  assert_stage2_after_stage1_R6: assert property (@(posedge clk) disable iff (rst || por)
    (!stage2_rst && !stage1_irq) |=> !stage2_rst);

  // R7: no warning rises while disarmed
  assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (rst || por)
    (!en_q && !stage1_irq) |=> !stage1_irq);

  // R3, R12: a kick on the refresh port leaves the warning clear
  assert_kick_clears_R3: assert property (@(posedge clk) disable iff (rst || por)
    (rf_wr && rf_addr == '0) |=> !stage1_irq);

  // R5: first expiry reloads the deadline from count and interval
  assert_first_reload_R5: assert property (@(posedge clk) disable iff (rst || por)
    $rose(stage1_irq) |-> (cmp_q == $past(sys_count) + CNT_W'($past(offset_q))));

  // R10: warm reset disarms and drops the warning
  assert_warm_clears_R10: assert property (@(posedge clk) disable iff (por)
    rst |=> (!en_q && !stage1_irq));
endmodule

bind twostage_wdog twostage_wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .por(por), .en_q(en_q), .stage1_irq(stage1_irq),
  .stage2_rst(stage2_rst), .rf_wr(rf_wr), .rf_addr(rf_addr),
  .sys_count(sys_count), .cmp_q(cmp_q), .offset_q(offset_q)
);

// File: tb/twostage_wdog_bench.sv
module twostage_wdog_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        por = 1'b1;
  logic [63:0] sys_count = '0;
  logic        rf_wr = 1'b0;
  logic [11:0] rf_addr = '0;
  logic        cf_wr = 1'b0;
  logic [11:0] cf_addr = '0;
  logic [31:0] cf_wdata = '0;
  logic [31:0] cf_rdata;
  logic        stage1_irq;
  logic        stage2_rst;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_wdog u_twostage_wdog (
    .clk(clk), .rst(rst), .por(por), .sys_count(sys_count),
    .rf_wr(rf_wr), .rf_addr(rf_addr), .cf_wr(cf_wr), .cf_addr(cf_addr),
    .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .stage1_irq(stage1_irq), .stage2_rst(stage2_rst)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cf_wr = 1'b1; cf_addr = a; cf_wdata = d;
    @(negedge clk);
    cf_wr = 1'b0;
  endtask

  task automatic cread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cf_addr = a;
    @(negedge clk);
    d = cf_rdata;
  endtask

  task automatic kick(input logic [11:0] a, input logic [63:0] cnt);
    @(negedge clk);
    rf_wr = 1'b1; rf_addr = a; sys_count = cnt;
    @(negedge clk);
    rf_wr = 1'b0;
  endtask

  task automatic set_count(input logic [63:0] cnt);
    @(negedge clk);
    sys_count = cnt;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    chk("R1 stage1", stage1_irq, 0);
    chk("R1 stage2", stage2_rst, 0);
    cread(12'h000, d); chk("R1 settings", d, 0);
    cread(12'h008, d); chk("R1 interval", d, 0);
    cread(12'h010, d); chk("R1 dl_lo", d, 0);
    cread(12'h014, d); chk("R1 dl_hi", d, 0);
    cread(12'hFCC, d); chk("R11 iface id", d, 32'h0001_043B);
    cread(12'hFD0, d); chk("R11 part id", d, 32'h0000_0A55);
    cread(12'h020, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    set_count(64'd1000);
    cwrite(12'h008, 32'd100);
    cread(12'h010, d); chk("R4 disabled interval write keeps deadline", d, 0);
    cread(12'h008, d); chk("R4 interval stored", d, 100);
    repeat (3) @(negedge clk);
    chk("R7 no expiry while disabled", stage1_irq, 0);
  endtask

  task automatic t_arm;
    logic [31:0] d;
    cwrite(12'h000, 32'h1);
    cread(12'h010, d); chk("R2 deadline after arm", d, 1100);
    cread(12'h000, d); chk("R2 enable read", d, 1);
  endtask

  task automatic t_two_stages;
    logic [31:0] d;
    set_count(64'd1099);
    chk("R5 before deadline", stage1_irq, 0);
    set_count(64'd1100);
    chk("R5 warning raised", stage1_irq, 1);
    cread(12'h010, d); chk("R5 deadline reloaded", d, 1200);
    cread(12'h000, d); chk("R11 settings after warning", d, 3);
    set_count(64'd1199);
    chk("R6 before second deadline", stage2_rst, 0);
    set_count(64'd1200);
    chk("R6 reset raised", stage2_rst, 1);
    cread(12'h000, d); chk("R11 settings after reset stage", d, 7);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    cwrite(12'h000, 32'h7);
    cread(12'h000, d); chk("R9 stage bits not writable", d, 5);
    chk("R9 reset stage kept", stage2_rst, 1);
    cread(12'h010, d); chk("R2 refresh deadline", d, 1300);
  endtask

  task automatic t_resets;
    logic [31:0] d;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 warm reset drops warning", stage1_irq, 0);
    chk("R10 warm reset keeps reset stage", stage2_rst, 1);
    cread(12'h000, d); chk("R10 settings after warm reset", d, 4);
    cread(12'h008, d); chk("R10 interval cleared", d, 0);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    chk("R1 power-on clears reset stage", stage2_rst, 0);
  endtask

  task automatic t_refresh_port;
    logic [31:0] d;
    set_count(64'd2000);
    cwrite(12'h008, 32'd50);
    cwrite(12'h000, 32'h1);
    set_count(64'd2050);
    chk("R5 warning again", stage1_irq, 1);
    kick(12'h004, 64'd2060);
    chk("R3 other offset ignored", stage1_irq, 1);
    cread(12'h010, d); chk("R3 other offset keeps deadline", d, 2100);
    kick(12'h000, 64'd2060);
    chk("R3 kick clears warning", stage1_irq, 0);
    cread(12'h010, d); chk("R3 kick deadline", d, 2110);
  endtask

  task automatic t_interval_armed;
    logic [31:0] d;
    cwrite(12'h008, 32'd300);
    cread(12'h010, d); chk("R4 armed interval write refreshes", d, 2360);
  endtask

  task automatic t_deadline_write;
    logic [31:0] d;
    set_count(64'd2360);
    chk("R5 warning for R8", stage1_irq, 1);
    cwrite(12'h010, 32'd9000);
    chk("R8 warning unchanged", stage1_irq, 1);
    cread(12'h000, d); chk("R8 stage bits unchanged", d, 3);
    cread(12'h010, d); chk("R8 low word", d, 9000);
    cwrite(12'h014, 32'd1);
    cread(12'h014, d); chk("R8 high word", d, 1);
    cwrite(12'h014, 32'd0);
    set_count(64'd2400);
    chk("R8 no expiry before new deadline", stage2_rst, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    kick(12'h000, 64'd9000);
    chk("R12 refresh beats expiry warning", stage1_irq, 0);
    chk("R12 refresh beats expiry reset", stage2_rst, 0);
    cread(12'h010, d); chk("R12 deadline from refresh", d, 9300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_disabled();
    t_arm();
    t_two_stages();
    t_readonly();
    t_resets();
    t_refresh_port();
    t_interval_armed();
    t_deadline_write();
    t_race();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule